// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block holds the feedback-divider word (M), the output-divider code (N) and a test-select field (T) for a frequency synthesizer. They can be written from two places. A parallel side presents M and N together with a level strobe. A serial side shifts a 14-bit frame in, one bit per serial clock, and commits the frame with a separate load strobe.

All three strobes and the serial data are sampled into the system clock domain, and their edges are detected there. Every configuration register therefore updates on the system clock. The block also decodes the N code into a one-hot divide modulus. It raises a flag whenever the active M lies outside the window in which the loop can lock.

The parallel strobe takes precedence over the serial side. While it is low, the parallel inputs flow straight into the active registers. While it is low, all serial activity is also ignored.

Top module: `synth_div_cfg`

## Requirements
- R1: While the synchronized parallel strobe is low, `m_out` and `n_code` take the values of `par_m` and `par_n` on each system clock. A change on those inputs therefore shows one clock later.
- R2: Once the parallel strobe has gone high, changes on `par_m` and `par_n` have no effect on `m_out` or `n_code`. The values present while the strobe was still low are kept.
- R3: Each rising edge of `ser_clk` shifts `ser_data` into the low end of a 14-bit shift register, but only while the parallel strobe is high. Serial clocks that arrive while the strobe is low shift nothing.
- R4: The frame is sent MSB first, in this order: T (3 bits), then N (2 bits), then M (9 bits). After 14 shifts, frame bits [13:11] hold T, bits [10:9] hold N and bits [8:0] hold M.
- R5: While the parallel strobe is high, a falling edge of `ser_load` copies the frame fields into `t_sel`, `n_code` and `m_out`. A falling edge of `ser_load` while the parallel strobe is low changes nothing.
- R6: `t_sel` is 000 whenever the parallel strobe is low. The parallel port has no way to set it.
- R7: `n_mod` is the one-hot divide modulus: code 00 gives 1 (4'b0001), 01 gives 2, 10 gives 4 and 11 gives 8 (4'b1000).
- R8: `m_bad` is 1 when `m_out` is below 200 or above 400, and 0 for values from 200 to 400 inclusive.
- R9: While reset is asserted, `m_out` is 0, `n_code` is 00 and `t_sel` is 000. The shift register is cleared to all zeros.
- R10: When more than 14 bits are shifted in before a commit, only the last 14 bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| par_strobe | input | 1 | Parallel strobe: low = transparent, high = hold |
| par_m | input | 9 | Parallel M word |
| par_n | input | 2 | Parallel N code |
| ser_clk | input | 1 | Serial shift clock (sampled) |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Serial commit strobe, active on its falling edge |
| m_out | output | 9 | Active M value |
| n_code | output | 2 | Active N code |
| n_mod | output | 4 | One-hot divide modulus (1, 2, 4, 8) |
| t_sel | output | 3 | Active test-select value |
| m_bad | output | 1 | Active M lies outside 200..400 |

## Verification
The bench probes the range flag exactly at 199, 200, 400 and 401. A comparison off by one at either end would flip the flag at one of those points.

It sends serial frames and commits them while the parallel strobe is low. A design that lets the serial side in at that time would corrupt M or show a nonzero T. It also sends an over-long frame: a design that counts bits instead of shifting would commit the wrong fields.

It drops the parallel strobe after a serial commit that set T. A design that keeps T would leave a stale test selection active.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
   // indices into the synchronizer bank
   localparam int SIG_PAR  = 0;
   localparam int SIG_SCLK = 1;
   localparam int SIG_SDAT = 2;
   localparam int SIG_SLD  = 3;
   localparam int NUM_SYNC = 4;

   typedef enum logic [1:0] {
      SRC_HOLD   = 2'd0,
      SRC_PAR    = 2'd1,
      SRC_SERIAL = 2'd2
   } cfg_src_e;
endpackage

// File: rtl/cfg_sync_edge.sv
module cfg_sync_edge #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] rise,
   output logic [WIDTH-1:0] fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cfg_sync_edge: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("cfg_sync_edge: WIDTH must be at least 1");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [STAGES:0] chain;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-1:0], async_in[i]};
      end

      assign lvl[i]  = chain[STAGES-1];
      assign rise[i] = chain[STAGES-1] & ~chain[STAGES];
      assign fall[i] = ~chain[STAGES-1] & chain[STAGES];
   end
endmodule

// File: rtl/cfg_shift_frame.sv
module cfg_shift_frame #(
   parameter int FRAME_W = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               shift_en,
   input  logic               bit_in,
   output logic [FRAME_W-1:0] frame
);
   if (FRAME_W < 2) begin : g_bad_frame
      $error("cfg_shift_frame: FRAME_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        frame <= '0;
      else if (shift_en) frame <= {frame[FRAME_W-2:0], bit_in};
   end

   // R3
   shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> frame == {$past(frame[FRAME_W-2:0]), $past(bit_in)});

   // R3
   shift_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(frame));
endmodule

// File: rtl/cfg_n_decode.sv
module cfg_n_decode #(
   parameter int N_W = 2,
   localparam int MOD_W = 1 << N_W
) (
   input  logic [N_W-1:0]   code,
   output logic [MOD_W-1:0] modulus
);
   if (N_W < 1 || N_W > 4) begin : g_bad_n
      $error("cfg_n_decode: N_W must lie in 1..4");
   end

   for (genvar k = 0; k < MOD_W; k++) begin : g_code
      assign modulus[k] = (code == N_W'(k));
   end
endmodule

// File: rtl/cfg_range_flag.sv
module cfg_range_flag #(
   parameter int M_W      = 9,
   parameter int M_MIN    = 200,
   parameter int M_MAX    = 400,
   parameter bit CHECK_EN = 1'b1
) (
   input  logic [M_W-1:0] m_val,
   output logic           out_of_range
);
   if (M_MIN > M_MAX) begin : g_bad_order
      $error("cfg_range_flag: M_MIN exceeds M_MAX");
   end
   if (M_MAX >= (1 << M_W)) begin : g_bad_max
      $error("cfg_range_flag: M_MAX does not fit in M_W bits");
   end

   localparam logic [M_W-1:0] LO = M_W'(M_MIN);
   localparam logic [M_W-1:0] HI = M_W'(M_MAX);

   if (CHECK_EN) begin : g_check
      logic below, above;
      assign below = (m_val < LO);
      assign above = (m_val > HI);
      assign out_of_range = below | above;
   end else begin : g_nocheck
      assign out_of_range = 1'b0;
   end
endmodule

// File: rtl/synth_div_cfg.sv
module synth_div_cfg #(
   parameter int M_W         = 9,
   parameter int N_W         = 2,
   parameter int T_W         = 3,
   parameter int SYNC_STAGES = 2,
   parameter int M_MIN       = 200,
   parameter int M_MAX       = 400,
   localparam int FRAME_W    = T_W + N_W + M_W,
   localparam int MOD_W      = 1 << N_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             par_strobe,
   input  logic [M_W-1:0]   par_m,
   input  logic [N_W-1:0]   par_n,
   input  logic             ser_clk,
   input  logic             ser_data,
   input  logic             ser_load,
   output logic [M_W-1:0]   m_out,
   output logic [N_W-1:0]   n_code,
   output logic [MOD_W-1:0] n_mod,
   output logic [T_W-1:0]   t_sel,
   output logic             m_bad
);
   import cfg_pkg::*;

   if (T_W < 1 || M_W < 1) begin : g_bad_fields
      $error("synth_div_cfg: field widths must be positive");
   end

   // field positions inside the frame (T sent first, so it lands highest)
   localparam int M_LSB = 0;
   localparam int N_LSB = M_W;
   localparam int T_LSB = M_W + N_W;

   logic [NUM_SYNC-1:0] raw_in, s_lvl, s_rise, s_fall;
   logic                par_lvl, ser_shift, ser_commit;
   logic [FRAME_W-1:0]  frame;
   logic [M_W-1:0]      m_q;
   logic [N_W-1:0]      n_q;
   logic [T_W-1:0]      t_q;
   cfg_src_e            src;

   always_comb begin
      raw_in           = '0;
      raw_in[SIG_PAR]  = par_strobe;
      raw_in[SIG_SCLK] = ser_clk;
      raw_in[SIG_SDAT] = ser_data;
      raw_in[SIG_SLD]  = ser_load;
   end

   cfg_sync_edge #(.STAGES(SYNC_STAGES), .WIDTH(NUM_SYNC)) sync_i (
      .clk(clk), .rst_n(rst_n), .async_in(raw_in),
      .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
   );

   assign par_lvl    = s_lvl[SIG_PAR];
   assign ser_shift  = s_rise[SIG_SCLK] & par_lvl;
   assign ser_commit = s_fall[SIG_SLD] & par_lvl;

   cfg_shift_frame #(.FRAME_W(FRAME_W)) shift_i (
      .clk(clk), .rst_n(rst_n), .shift_en(ser_shift),
      .bit_in(s_lvl[SIG_SDAT]), .frame(frame)
   );

   always_comb begin
      if (!par_lvl)        src = SRC_PAR;
      else if (ser_commit) src = SRC_SERIAL;
      else                 src = SRC_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_q <= '0;
         n_q <= '0;
         t_q <= '0;
      end else begin
         case (src)
            SRC_PAR: begin
               m_q <= par_m;
               n_q <= par_n;
               t_q <= '0;
            end
            SRC_SERIAL: begin
               m_q <= frame[M_LSB +: M_W];
               n_q <= frame[N_LSB +: N_W];
               t_q <= frame[T_LSB +: T_W];
            end
            default: ;
         endcase
      end
   end

   cfg_n_decode #(.N_W(N_W)) dec_i (.code(n_q), .modulus(n_mod));

   cfg_range_flag #(.M_W(M_W), .M_MIN(M_MIN), .M_MAX(M_MAX), .CHECK_EN(1'b1)) rng_i (
      .m_val(m_q), .out_of_range(m_bad)
   );

   assign m_out  = m_q;
   assign n_code = n_q;
   assign t_sel  = t_q;

   // R1
   par_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !par_lvl |=> (m_out == $past(par_m)) && (n_code == $past(par_n)));

   // R2
   par_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (par_lvl && !ser_commit) |=> $stable(m_out) && $stable(n_code) && $stable(t_sel));

   // R5
   ser_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ser_commit |=> (m_out == $past(frame[M_W-1:0])) &&
                     (t_sel == $past(frame[FRAME_W-1 -: T_W])));

   // R6
   test_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !par_lvl |=> t_sel == '0);

   // R7
   nmod_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(n_mod) == 1);

   // R8
   range_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(m_out) >= M_MIN && int'(m_out) <= M_MAX) |-> !m_bad);
endmodule

// File: tb/synth_div_cfg_tb_top.sv
module synth_div_cfg_tb_top;
   localparam int CLK_P = 10;
   localparam int NV    = 8;
   // vector: {m[8:0], n[1:0], expected n_mod[3:0], expected m_bad}
   localparam logic [15:0] VEC [NV] = '{
      {9'd0,   2'd0, 4'b0001, 1'b1},
      {9'd199, 2'd1, 4'b0010, 1'b1},
      {9'd200, 2'd2, 4'b0100, 1'b0},
      {9'd400, 2'd3, 4'b1000, 1'b0},
      {9'd401, 2'd0, 4'b0001, 1'b1},
      {9'd262, 2'd1, 4'b0010, 1'b0},
      {9'd511, 2'd2, 4'b0100, 1'b1},
      {9'd300, 2'd3, 4'b1000, 1'b0}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic par_strobe = 1'b0, ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
   logic [8:0] par_m = '0;
   logic [1:0] par_n = '0;
   logic [8:0] m_out;
   logic [1:0] n_code;
   logic [3:0] n_mod;
   logic [2:0] t_sel;
   logic       m_bad;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   synth_div_cfg dut_i (
      .clk(clk), .rst_n(rst_n), .par_strobe(par_strobe), .par_m(par_m), .par_n(par_n),
      .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
      .m_out(m_out), .n_code(n_code), .n_mod(n_mod), .t_sel(t_sel), .m_bad(m_bad)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (6) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk) ser_data = b;
      @(negedge clk) ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic send_frame(input logic [2:0] t, input logic [1:0] n, input logic [8:0] m);
      logic [13:0] f;
      f = {t, n, m};
      for (int i = 13; i >= 0; i--) send_bit(f[i]);
   endtask

   task automatic pulse_load();
      @(negedge clk) ser_load = 1'b1;
      repeat (5) @(negedge clk);
      ser_load = 1'b0;
      settle();
   endtask

   task automatic expect_all(input string req, input int m, input int n, input int t);
      check({req, " m"}, int'(m_out), m);
      check({req, " n"}, int'(n_code), n);
      check({req, " t"}, int'(t_sel), t);
   endtask

   initial begin
      // R9 reset state
      repeat (3) @(negedge clk);
      expect_all("R9 reset", 0, 0, 0);
      check("R8 reset flag", int'(m_bad), 1);
      check("R7 reset nmod", int'(n_mod), 1);
      rst_n = 1'b1;
      settle();

      // R1 R7 R8 vector walk with parallel strobe low
      for (int v = 0; v < NV; v++) begin
         par_m = VEC[v][15:7];
         par_n = VEC[v][6:5];
         @(negedge clk);
         @(negedge clk);
         check("R1 m", int'(m_out), int'(VEC[v][15:7]));
         check("R1 n", int'(n_code), int'(VEC[v][6:5]));
         check("R7 nmod", int'(n_mod), int'(VEC[v][4:1]));
         check("R8 flag", int'(m_bad), int'(VEC[v][0]));
         check("R6 t", int'(t_sel), 0);
      end

      // R2 freeze on rising strobe
      par_m = 9'd262; par_n = 2'd1;
      settle();
      par_strobe = 1'b1;
      settle();
      par_m = 9'd100; par_n = 2'd3;
      settle();
      expect_all("R2 freeze", 262, 1, 0);

      // R3 shifting alone changes nothing active
      send_frame(3'b101, 2'b10, 9'd300);
      expect_all("R3 no commit yet", 262, 1, 0);

      // R4 R5 commit
      pulse_load();
      expect_all("R5 commit", 300, 2, 5);
      check("R4 nmod", int'(n_mod), 4);
      check("R8 in range", int'(m_bad), 0);

      // R10 over-long frame: three junk bits first
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      send_frame(3'b011, 2'b11, 9'd150);
      pulse_load();
      expect_all("R10 last14", 150, 3, 3);
      check("R10 flag", int'(m_bad), 1);

      // R6 dropping strobe clears T, parallel takes over
      par_m = 9'd250; par_n = 2'd1;
      par_strobe = 1'b0;
      settle();
      expect_all("R6 clear", 250, 1, 0);

      // R3 shifts while strobe low are ignored; R5 load while low ignored
      send_frame(3'b111, 2'b00, 9'd333);
      pulse_load();
      expect_all("R5 load ignored", 250, 1, 0);
      par_strobe = 1'b1;
      settle();
      pulse_load();
      expect_all("R3 ignored shift", 150, 3, 3);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule